// File: doc/BRIEF.md
# Bidirectional Latched Octal Transceiver

This block passes 8-bit data both ways between two ports, A and B. Each direction owns a bank of latches and three active-low controls: an enable, a latch-open control and a drive control. Data taken in from A is held in the A-to-B bank and may be driven onto B. Data taken in from B is held in the B-to-A bank and may be driven onto A. The path is non-inverting.

The bidirectional pins are not modelled as tri-state nets. Each port exposes a data-in vector, a data-out vector and a single drive flag, and a wrapper may merge them into inout nets. Storage is modelled on a clock. While a bank is open, its output follows its source without delay and the bank loads the source at every rising edge. Once the bank closes, it shows the value it loaded at the last edge where it was open. A synchronous active-high reset clears both banks.

When both directions are told to drive at once, the block asserts both drive flags and leaves the contention to the system around it.

Top module: `xcvr_bidir_latch`

## Requirements
- R1: A rising clock edge with `rst` high clears both banks to zero. A closed bank that is driving then presents 0x00.
- R2: With a direction's enable low (0) and its latch-open control low (0), the bank is open. Its output equals its source port (A for A-to-B, B for B-to-A) bit for bit, in the same cycle, and the bank loads that source at each rising edge.
- R3: With the enable low and the latch-open control high (1), the bank is closed. It presents the value loaded at the last rising edge where it was open, and changes on the source port do not alter it.
- R4: With a direction's enable high, its bank neither loads nor follows its source, whatever the other two controls are. Its drive flag is 0 and its data-out is 0x00.
- R5: With a direction's drive control high, its drive flag is 0 and its data-out is 0x00. Loading continues as in R2 and R3.
- R6: A direction's drive flag is 1 exactly when its enable and its drive control are both low. Its data-out then equals the bank view (source if open, stored value if closed).
- R7: The B-to-A direction obeys R2 to R6 with its own controls and drives A. Neither direction's controls affect the other direction's bank.
- R8: When both directions meet the drive condition of R6, both drive flags are 1. No arbitration takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bank loading |
| rst | input | 1 | Synchronous active-high reset of both banks |
| a_din | input | DATA_W | Value seen on port A |
| a_dout | output | DATA_W | Value driven onto A by the B-to-A direction |
| a_drv | output | 1 | High when A is driven |
| b_din | input | DATA_W | Value seen on port B |
| b_dout | output | DATA_W | Value driven onto B by the A-to-B direction |
| b_drv | output | 1 | High when B is driven |
| ab_en_n | input | 1 | A-to-B enable, active low |
| ab_open_n | input | 1 | A-to-B latch-open control, active low |
| ab_drive_n | input | 1 | A-to-B drive control, active low |
| ba_en_n | input | 1 | B-to-A enable, active low |
| ba_open_n | input | 1 | B-to-A latch-open control, active low |
| ba_drive_n | input | 1 | B-to-A drive control, active low |

## Verification
The bench builds the block with DATA_W = 8, the default. It steps through all 64 combinations of the six control bits, and each combination is applied with four data patterns. Each step is applied after the bank state left by the step before it, so the sweep reaches opening, closing, blocked loads, gated drive and both-driving contention, all from many different stored values. Directed sequences check the reset value and the capture when a bank closes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_DATA_W = 8;
    localparam int unsigned XCVR_DIRS   = 2;
    localparam int unsigned DIR_AB      = 0;
    localparam int unsigned DIR_BA      = 1;

    typedef struct packed {
        logic en_n;
        logic open_n;
        logic drive_n;
    } dir_ctrl_t;

    typedef enum logic [1:0] {
        MODE_BLOCKED = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_FOLLOW  = 2'd2
    } latch_mode_e;

    typedef struct packed {
        logic load;
        logic follow;
        logic drive;
    } dir_cmd_t;

    function automatic latch_mode_e mode_of(dir_ctrl_t c);
        if (c.en_n) begin
            return MODE_BLOCKED;
        end
        if (c.open_n) begin
            return MODE_HOLD;
        end
        return MODE_FOLLOW;
    endfunction

    function automatic logic drive_of(dir_ctrl_t c);
        return ~(c.en_n | c.drive_n);
    endfunction

endpackage

// File: rtl/xcvr_ctrl_decode.sv
module xcvr_ctrl_decode
    import xcvr_pkg::*;
(
    input  dir_ctrl_t ctrl,
    output dir_cmd_t  cmd
);

    latch_mode_e mode;

    always_comb begin
        mode       = mode_of(ctrl);
        cmd.load   = (mode == MODE_FOLLOW);
        cmd.follow = (mode == MODE_FOLLOW);
        cmd.drive  = drive_of(ctrl);
    end

endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
    import xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = XCVR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  dir_cmd_t          cmd,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] view
);

    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (cmd.load) begin
            held_q <= src;
        end
    end

    always_comb begin
        view = cmd.follow ? src : held_q;
    end

endmodule

// File: rtl/xcvr_port_gate.sv
module xcvr_port_gate
    import xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = XCVR_DATA_W
) (
    input  dir_cmd_t          cmd,
    input  logic [DATA_W-1:0] view,
    output logic [DATA_W-1:0] dout,
    output logic              drv
);

    always_comb begin
        drv  = cmd.drive;
        dout = cmd.drive ? view : '0;
    end

endmodule

// File: rtl/xcvr_bidir_latch.sv
module xcvr_bidir_latch
    import xcvr_pkg::*;
#(
    parameter int unsigned DATA_W = XCVR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_drv,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_drv,
    input  logic              ab_en_n,
    input  logic              ab_open_n,
    input  logic              ab_drive_n,
    input  logic              ba_en_n,
    input  logic              ba_open_n,
    input  logic              ba_drive_n
);

    dir_ctrl_t         ctrl_v [XCVR_DIRS];
    logic [DATA_W-1:0] src_v  [XCVR_DIRS];
    logic [DATA_W-1:0] dout_v [XCVR_DIRS];
    logic              drv_v  [XCVR_DIRS];

    always_comb begin
        ctrl_v[DIR_AB] = '{en_n: ab_en_n, open_n: ab_open_n, drive_n: ab_drive_n};
        ctrl_v[DIR_BA] = '{en_n: ba_en_n, open_n: ba_open_n, drive_n: ba_drive_n};
        src_v[DIR_AB]  = a_din;
        src_v[DIR_BA]  = b_din;
    end

    for (genvar d = 0; d < XCVR_DIRS; d++) begin : g_dir
        dir_cmd_t          cmd;
        logic [DATA_W-1:0] view;

        xcvr_ctrl_decode u_dec (
            .ctrl (ctrl_v[d]),
            .cmd  (cmd)
        );

        xcvr_latch_bank #(.DATA_W(DATA_W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .cmd  (cmd),
            .src  (src_v[d]),
            .view (view)
        );

        xcvr_port_gate #(.DATA_W(DATA_W)) u_gate (
            .cmd  (cmd),
            .view (view),
            .dout (dout_v[d]),
            .drv  (drv_v[d])
        );
    end

    assign b_dout = dout_v[DIR_AB];
    assign b_drv  = drv_v[DIR_AB];
    assign a_dout = dout_v[DIR_BA];
    assign a_drv  = drv_v[DIR_BA];

endmodule

// File: rtl/xcvr_bidir_latch_chk.sv
module xcvr_bidir_latch_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_din,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_drv,
    input logic [DATA_W-1:0] b_din,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_drv,
    input logic              ab_en_n,
    input logic              ab_open_n,
    input logic              ab_drive_n,
    input logic              ba_en_n,
    input logic              ba_open_n,
    input logic              ba_drive_n
);

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ab_en_n && ab_open_n && !ab_drive_n) |-> (b_dout == '0)); // R1

    AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && !ab_open_n && !ab_drive_n) |-> (b_dout == a_din)); // R2

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && ab_open_n && !ab_drive_n && $past(!rst)
         && $past(!ab_en_n && ab_open_n && !ab_drive_n)) |-> $stable(b_dout)); // R3

    AST_AB_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        ab_en_n |-> (!b_drv && b_dout == '0)); // R4

    AST_AB_GATED: assert property (@(posedge clk) disable iff (rst)
        ab_drive_n |-> (!b_drv && b_dout == '0)); // R5

    AST_BA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!ba_en_n && !ba_open_n && !ba_drive_n) |-> (a_dout == b_din)); // R7

    AST_BOTH_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && !ab_drive_n && !ba_en_n && !ba_drive_n) |-> (a_drv && b_drv)); // R8

endmodule

bind xcvr_bidir_latch xcvr_bidir_latch_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/xcvr_bidir_latch_tb.sv
module xcvr_bidir_latch_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic [W-1:0] a_dout, b_dout;
    logic         a_drv, b_drv;
    logic         ab_en_n = 1'b1, ab_open_n = 1'b1, ab_drive_n = 1'b1;
    logic         ba_en_n = 1'b1, ba_open_n = 1'b1, ba_drive_n = 1'b1;

    int n_vec  = 0;
    int n_fail = 0;
    int n_contention = 0;
    bit finished = 1'b0;

    logic [W-1:0] mdl_ab = '0, mdl_ba = '0;

    always #2 clk = ~clk;

    xcvr_bidir_latch #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_din(a_din), .a_dout(a_dout), .a_drv(a_drv),
        .b_din(b_din), .b_dout(b_dout), .b_drv(b_drv),
        .ab_en_n(ab_en_n), .ab_open_n(ab_open_n), .ab_drive_n(ab_drive_n),
        .ba_en_n(ba_en_n), .ba_open_n(ba_open_n), .ba_drive_n(ba_drive_n)
    );

    // Reference model of the stored values, from R1, R2, R4
    always @(posedge clk) begin
        if (rst) begin
            mdl_ab <= '0;
            mdl_ba <= '0;
        end else begin
            if (!ab_en_n && !ab_open_n) mdl_ab <= a_din;
            if (!ba_en_n && !ba_open_n) mdl_ba <= b_din;
        end
    end

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_dir(input string dirtag, input logic en_n, input logic open_n,
                             input logic drive_n, input logic [W-1:0] src,
                             input logic [W-1:0] held, input logic [W-1:0] dout,
                             input logic drv);
        logic [W-1:0] view;
        logic         edrv;
        string        tag;
        view = (!en_n && !open_n) ? src : held;
        edrv = !en_n && !drive_n;
        if (en_n)        tag = "R4";
        else if (drive_n) tag = "R5";
        else if (!open_n) tag = "R2";
        else              tag = "R3";
        check({dirtag, " ", tag, " R6"}, {drv, dout}, {edrv, edrv ? view : {W{1'b0}}});
    endtask

    task automatic apply(input logic [5:0] ctl, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        {ab_en_n, ab_open_n, ab_drive_n, ba_en_n, ba_open_n, ba_drive_n} = ctl;
        a_din = a;
        b_din = b;
        #1;
        check_dir("AB", ab_en_n, ab_open_n, ab_drive_n, a_din, mdl_ab, b_dout, b_drv);
        check_dir("BA R7", ba_en_n, ba_open_n, ba_drive_n, b_din, mdl_ba, a_dout, a_drv);
        if (!ab_en_n && !ab_drive_n && !ba_en_n && !ba_drive_n) begin
            n_contention++;
            check("R8 both drive", {7'd0, a_drv, b_drv}, 9'd3);
        end
    endtask

    initial begin : watchdog
        #400000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: both banks closed and driving show zero after reset
        apply(6'b010_010, 8'hA5, 8'h3C);
        check("R1 b_dout after reset", {b_drv, b_dout}, {1'b1, 8'h00});
        check("R1 a_dout after reset", {a_drv, a_dout}, {1'b1, 8'h00});

        // R3: capture on closing, then source changes are ignored
        apply(6'b000_010, 8'h5A, 8'h00);
        check("R2 follow", {1'b0, b_dout}, {1'b0, 8'h5A});
        apply(6'b010_010, 8'hC3, 8'h00);
        check("R3 captured on close", {1'b0, b_dout}, {1'b0, 8'h5A});
        apply(6'b010_010, 8'h0F, 8'h00);
        check("R3 hold ignores A", {1'b0, b_dout}, {1'b0, 8'h5A});

        // R4: enable high blocks loading even with latch-open low
        apply(6'b100_010, 8'hFF, 8'h00);
        apply(6'b010_010, 8'h11, 8'h00);
        check("R4 no load while disabled", {1'b0, b_dout}, {1'b0, 8'h5A});

        // R7: B-to-A capture independent of A-to-B controls
        apply(6'b110_000, 8'h00, 8'h96);
        apply(6'b000_010, 8'h77, 8'h21);
        check("R7 BA held", {1'b0, a_dout}, {1'b0, 8'h96});

        // Exhaustive sweep of control combinations with several data patterns
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 64; c++) begin
                logic [W-1:0] av;
                logic [W-1:0] bv;
                av = W'((c * 37 + p * 91 + 5) & 255);
                bv = ~av ^ W'(p * 17);
                apply(c[5:0], av, bv);
            end
        end

        // R1: reset in mid-run clears stored values
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        apply(6'b010_010, 8'hEE, 8'hDD);
        check("R1 mid-run reset AB", {1'b0, b_dout}, {1'b0, 8'h00});
        check("R1 mid-run reset BA", {1'b0, a_dout}, {1'b0, 8'h00});

        if (n_contention == 0) begin
            n_fail++;
            $display("FAIL R8 contention never reached actual=0 expected>0");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule